// File: doc/BRIEF.md
# Receive FIFO Packet Framer

The block takes a received Ethernet frame as a byte stream, one byte per clock, with error flags that arrive alongside the final byte. It stores each accepted frame in a word-wide FIFO as a self-describing record. The first word of a record is a constant marker. The second word carries the receive status and the byte count. The frame bytes follow, packed four to a word, with zero padding in the unused lanes of the last word. A host drains the FIFO through a single 32-bit data port, where each pop removes one word. The host learns how many whole records are waiting from a frame counter.

A record becomes visible to the host only once its final byte has been written. A frame that is rejected is discarded and leaves no trace in the FIFO. A frame can be rejected because reception is switched off during the frame, because the FIFO fills up part-way through it, or because a flush cuts across it. A flush request empties the FIFO. It shows as a busy flag for one cycle and then clears by itself. Each stored record raises a receive event flag that the host acknowledges.

Top module: `rx_fifo_framer`

## Requirements
- R1: The first word of every stored record is the constant 0x0143414D.
- R2: The second word holds the frame byte count in bits 15:0. Bits 23, 22, 21 and 20 are, in that order, the good flag, the alignment error, the length error and the CRC error. The good flag is set only when all three error inputs are 0 on the last byte. All other bits are 0.
- R3: Frame byte k is stored in data word k/4 at bits 8*(k mod 4)+7 down to 8*(k mod 4). There are ceil(length/4) data words, and the unused lanes of the last word read as 0. The byte count includes every byte received, FCS included.
- R4: A pop with `pop_avail` high removes exactly one word. A pop while `pop_avail` is low changes nothing, and later records still read back correctly.
- R5: `pop_avail` stays low until the cycle after the last byte of a frame has been accepted. Words of an incomplete frame are never visible.
- R6: `frame_count` rises by one when a record is completed and falls by one when the host pops a record's marker word. When both happen in the same cycle it is unchanged, and it never decrements below 0.
- R7: A `count_clear` pulse makes `frame_count` read 0 in the following cycle. The stored data is not affected.
- R8: A `flush_req` pulse makes `flush_busy` read 1 for exactly one cycle, after which it reads 0. The flush empties the FIFO and zeroes `frame_count`. The rest of any frame in progress is discarded up to and including its last byte.
- R9: If `rx_en` is low on any byte of a frame, that whole frame is discarded.
- R10: A frame whose record does not fit in the free space is discarded, and records already stored stay intact. A record that exactly fills the FIFO is accepted.
- R11: `irq_rx` is set in the cycle after a record completes and cleared by `irq_ack`. When both happen in the same cycle, the set wins.
- R12: After reset `pop_avail`, `frame_count`, `irq_rx` and `flush_busy` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| rx_en | input | 1 | Reception enable, sampled on every byte |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| in_err_align | input | 1 | Alignment error, valid with the last byte |
| in_err_len | input | 1 | Length error, valid with the last byte |
| in_err_crc | input | 1 | CRC error, valid with the last byte |
| pop | input | 1 | Host pops the word shown on pop_data |
| pop_data | output | 32 | Word at the head of the FIFO |
| pop_avail | output | 1 | A completed word is available |
| frame_count | output | CNT_W | Number of complete records waiting |
| count_clear | input | 1 | Set frame_count to 0 |
| flush_req | input | 1 | Request a FIFO flush |
| flush_busy | output | 1 | Flush in progress, clears by itself |
| irq_rx | output | 1 | Record-completed event flag |
| irq_ack | input | 1 | Clear irq_rx |

## Verification
The bench aims at the packing boundaries: one-byte frames, frames of exactly four bytes, and frames of other lengths that leave the last word partly filled. A lane or rounding error in the design shows up as shifted bytes or a missing or extra data word, and every later record then reads back out of step. It fills the FIFO to exactly full, then sends a frame that overflows after some of its words are already written. A rollback that went wrong would leave stray words visible, or would reject the frame that exactly fits. It also lines up the completion of a record with the host popping another record's marker, and a completion with an event acknowledge. An incorrect counter or event-flag priority would drift by one or lose the event. It cuts a frame with a flush and with rx_en going low mid-frame. A design that failed to keep discarding would store the tail as a new record.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

  localparam logic [31:0] RXF_MARKER = 32'h0143_414D;
  localparam int          LEN_W      = 16;

  typedef enum logic [1:0] {
    PH_MARKER = 2'd0,
    PH_HEADER = 2'd1,
    PH_DATA   = 2'd2
  } rd_phase_e;

  // Status/length word: status bits live in the upper half.
  function automatic logic [31:0] pack_header(input logic [LEN_W-1:0] len,
                                              input logic e_align,
                                              input logic e_len,
                                              input logic e_crc);
    logic ok;
    ok = ~(e_align | e_len | e_crc);
    return {8'h00, ok, e_align, e_len, e_crc, 4'h0, len};
  endfunction

  // Number of data words needed for a byte count (rounded up).
  function automatic logic [LEN_W-1:0] words_of(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(3);
    return {1'b0, t[LEN_W:2]};
  endfunction

  // Insert a byte into its lane of a partially built word.
  function automatic logic [31:0] merge_byte(input logic [31:0] acc,
                                             input logic [1:0]  lane,
                                             input logic [7:0]  b);
    logic [31:0] r;
    r = acc;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/rxf_packer.sv
`timescale 1ns/1ps
module rxf_packer
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             word_valid,
  output logic [31:0]      word,
  output logic [LEN_W-1:0] frame_len,
  output logic             first_byte,
  output logic             frame_open
);

  logic [31:0]      acc;
  logic [1:0]       lane;
  logic [LEN_W-1:0] cnt;
  logic [31:0]      merged;

  assign merged     = merge_byte(acc, lane, in_byte);
  assign word       = merged;
  assign word_valid = in_valid && ((lane == 2'd3) || in_last);
  assign frame_len  = cnt + LEN_W'(1);
  assign first_byte = in_valid && !frame_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      lane       <= '0;
      cnt        <= '0;
      frame_open <= 1'b0;
    end else if (in_valid) begin
      frame_open <= !in_last;
      cnt        <= in_last ? '0 : cnt + LEN_W'(1);
      if (word_valid) begin
        acc  <= '0;
        lane <= '0;
      end else begin
        acc  <= merged;
        lane <= lane + 2'd1;
      end
    end
  end

endmodule

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we_data,
  input  logic [AW-1:0] a_data,
  input  logic [31:0]   d_data,
  input  logic          we_mark,
  input  logic [AW-1:0] a_mark,
  input  logic [31:0]   d_mark,
  input  logic          we_head,
  input  logic [AW-1:0] a_head,
  input  logic [31:0]   d_head,
  input  logic [AW-1:0] a_read,
  output logic [31:0]   q_read
);

  localparam int WORDS = 1 << AW;

  logic [31:0] mem [WORDS];

  // The three write addresses are always distinct when enabled together.
  always_ff @(posedge clk) begin
    if (we_data) mem[a_data] <= d_data;
    if (we_mark) mem[a_mark] <= d_mark;
    if (we_head) mem[a_head] <= d_head;
  end

  assign q_read = mem[a_read];

endmodule

// File: rtl/rxf_reader.sv
`timescale 1ns/1ps
module rxf_reader
  import rxf_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pop,
  input  logic [PTR_W-1:0] commit_ptr,
  input  logic [LEN_W-1:0] head_len,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             avail,
  output logic             pop_ok,
  output logic             marker_pop
);

  rd_phase_e        phase;
  logic [LEN_W-1:0] left;

  assign avail      = (rd_ptr != commit_ptr);
  assign pop_ok     = pop && avail && !flush;
  assign marker_pop = pop_ok && (phase == PH_MARKER);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      phase  <= PH_MARKER;
      left   <= '0;
    end else if (pop_ok) begin
      rd_ptr <= rd_ptr + PTR_W'(1);
      unique case (phase)
        PH_MARKER: phase <= PH_HEADER;
        PH_HEADER: begin
          left  <= words_of(head_len);
          phase <= PH_DATA;
        end
        default: begin
          if (left == LEN_W'(1)) phase <= PH_MARKER;
          left <= left - LEN_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/rx_fifo_framer.sv
`timescale 1ns/1ps
module rx_fifo_framer
  import rxf_pkg::*;
#(
  parameter int DEPTH_LOG2 = 6,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  input  logic             in_err_align,
  input  logic             in_err_len,
  input  logic             in_err_crc,
  input  logic             pop,
  output logic [31:0]      pop_data,
  output logic             pop_avail,
  output logic [CNT_W-1:0] frame_count,
  input  logic             count_clear,
  input  logic             flush_req,
  output logic             flush_busy,
  output logic             irq_rx,
  input  logic             irq_ack
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int PTR_W = DEPTH_LOG2 + 1;

  // Packer outputs
  logic             pk_word_valid;
  logic [31:0]      pk_word;
  logic [LEN_W-1:0] pk_len;
  logic             pk_first;
  logic             pk_open;

  // Pointers and named events
  logic [PTR_W-1:0] wr_ptr, commit_ptr, rd_ptr, data_ptr, occ;
  logic             dropping, drop_cur, keep, fits;
  logic             write_evt, overflow_evt, commit_evt;
  logic             pop_ok, marker_pop;
  logic [31:0]      head_word;

  rxf_packer u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_last    (in_last),
    .word_valid (pk_word_valid),
    .word       (pk_word),
    .frame_len  (pk_len),
    .first_byte (pk_first),
    .frame_open (pk_open)
  );

  // A new frame reserves two slots (marker, header) ahead of its data.
  assign drop_cur     = pk_first ? 1'b0 : dropping;
  assign keep         = in_valid && rx_en && !drop_cur && !flush_busy;
  assign data_ptr     = pk_first ? commit_ptr + PTR_W'(2) : wr_ptr;
  assign occ          = data_ptr - rd_ptr;
  assign fits         = occ < PTR_W'(DEPTH);
  assign write_evt    = keep && pk_word_valid && fits;
  assign overflow_evt = keep && pk_word_valid && !fits;
  assign commit_evt   = write_evt && in_last;
  assign head_word    = pack_header(pk_len, in_err_align, in_err_len, in_err_crc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
      dropping   <= 1'b0;
    end else if (flush_busy) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
      dropping   <= in_valid ? !in_last : pk_open;
    end else if (in_valid) begin
      if (!keep || overflow_evt) begin
        dropping <= !in_last;
        wr_ptr   <= commit_ptr;
      end else begin
        dropping <= 1'b0;
        wr_ptr   <= write_evt ? data_ptr + PTR_W'(1) : data_ptr;
      end
      if (commit_evt) commit_ptr <= data_ptr + PTR_W'(1);
    end
  end

  rxf_store #(.AW(DEPTH_LOG2)) u_store (
    .clk     (clk),
    .we_data (write_evt),
    .a_data  (data_ptr[DEPTH_LOG2-1:0]),
    .d_data  (pk_word),
    .we_mark (commit_evt),
    .a_mark  (commit_ptr[DEPTH_LOG2-1:0]),
    .d_mark  (RXF_MARKER),
    .we_head (commit_evt),
    .a_head  (commit_ptr[DEPTH_LOG2-1:0] + DEPTH_LOG2'(1)),
    .d_head  (head_word),
    .a_read  (rd_ptr[DEPTH_LOG2-1:0]),
    .q_read  (pop_data)
  );

  rxf_reader #(.PTR_W(PTR_W)) u_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_busy),
    .pop        (pop),
    .commit_ptr (commit_ptr),
    .head_len   (pop_data[LEN_W-1:0]),
    .rd_ptr     (rd_ptr),
    .avail      (pop_avail),
    .pop_ok     (pop_ok),
    .marker_pop (marker_pop)
  );

  // Frame counter, flush sequencing and the receive event flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_count <= '0;
      flush_busy  <= 1'b0;
      irq_rx      <= 1'b0;
    end else begin
      flush_busy <= flush_req;
      if (flush_busy || count_clear) begin
        frame_count <= '0;
      end else if (commit_evt && !marker_pop) begin
        frame_count <= frame_count + CNT_W'(1);
      end else if (!commit_evt && marker_pop && (frame_count != '0)) begin
        frame_count <= frame_count - CNT_W'(1);
      end
      if (commit_evt)   irq_rx <= 1'b1;
      else if (irq_ack) irq_rx <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_fifo_framer_chk.sv
`timescale 1ns/1ps
module rx_fifo_framer_chk #(
  parameter int PTR_W = 7,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit_evt,
  input logic             marker_pop,
  input logic             flush_busy,
  input logic             count_clear,
  input logic             pop,
  input logic             pop_avail,
  input logic             irq_rx,
  input logic [CNT_W-1:0] frame_count,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] commit_ptr
);

  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1 << (PTR_W - 1));

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> irq_rx);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (!pop_avail && frame_count == '0));

  // R7
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_clear |=> (frame_count == '0));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !pop_avail && !flush_busy) |=> $stable(rd_ptr));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PTR_W'(commit_ptr - rd_ptr) <= DEPTH_V));

  // R6
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !marker_pop && !count_clear && !flush_busy)
      |=> (frame_count == $past(frame_count) + CNT_W'(1)));

endmodule

bind rx_fifo_framer rx_fifo_framer_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit_evt  (commit_evt),
  .marker_pop  (marker_pop),
  .flush_busy  (flush_busy),
  .count_clear (count_clear),
  .pop         (pop),
  .pop_avail   (pop_avail),
  .irq_rx      (irq_rx),
  .frame_count (frame_count),
  .rd_ptr      (rd_ptr),
  .commit_ptr  (commit_ptr)
);

// File: tb/tb_rx_fifo_framer.sv
`timescale 1ns/1ps
module tb_rx_fifo_framer;

  localparam int DL    = 6;
  localparam int DEPTH = 1 << DL;
  localparam int CW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic          in_last = 1'b0;
  logic          in_err_align = 1'b0;
  logic          in_err_len = 1'b0;
  logic          in_err_crc = 1'b0;
  logic          pop = 1'b0;
  logic [31:0]   pop_data;
  logic          pop_avail;
  logic [CW-1:0] frame_count;
  logic          count_clear = 1'b0;
  logic          flush_req = 1'b0;
  logic          flush_busy;
  logic          irq_rx;
  logic          irq_ack = 1'b0;

  rx_fifo_framer #(.DEPTH_LOG2(DL), .CNT_W(CW)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  bit          mark_q[$];
  int          exp_count = 0;

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int tag, int k);
    return 8'((tag * 29 + k * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] head_model(int len, bit a, bit l, bit c);
    logic [31:0] h;
    h = 32'(len & 16'hFFFF);
    if (a) h = h | (32'd1 << 22);
    if (l) h = h | (32'd1 << 21);
    if (c) h = h | (32'd1 << 20);
    if (!(a || l || c)) h = h | (32'd1 << 23);
    return h;
  endfunction

  task automatic model_frame(int len, int tag, bit a, bit l, bit c);
    int nw;
    nw = (len + 3) / 4;
    if (exp_q.size() + 2 + nw <= DEPTH) begin
      exp_q.push_back(32'h0143414D); mark_q.push_back(1'b1);
      exp_q.push_back(head_model(len, a, l, c)); mark_q.push_back(1'b0);
      for (int w = 0; w < nw; w++) begin
        logic [31:0] v;
        v = '0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < len) v = v | (32'(byte_of(tag, 4 * w + b)) << (8 * b));
        exp_q.push_back(v); mark_q.push_back(1'b0);
      end
      exp_count++;
    end
  endtask

  task automatic model_pop();
    if (mark_q[0] && exp_count > 0) exp_count--;
    void'(exp_q.pop_front());
    void'(mark_q.pop_front());
  endtask

  // Called right after a negedge; returns right after a negedge.
  task automatic send(int len, int tag, bit a, bit l, bit c, int off_at,
                      int flush_at, bit pop_last, bit ack_last);
    bit was_empty;
    was_empty = (exp_q.size() == 0);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      if (flush_at >= 0 && k == flush_at + 1) check_eq("R8 busy set", 32'(flush_busy), 1);
      if (flush_at >= 0 && k == flush_at + 2) check_eq("R8 busy cleared", 32'(flush_busy), 0);
      if (k == len - 1 && was_empty && flush_at < 0)
        check_eq("R5 partial frame hidden", 32'(pop_avail), 0);
      in_valid     = 1'b1;
      in_byte      = byte_of(tag, k);
      in_last      = (k == len - 1);
      in_err_align = (k == len - 1) ? a : 1'b0;
      in_err_len   = (k == len - 1) ? l : 1'b0;
      in_err_crc   = (k == len - 1) ? c : 1'b0;
      rx_en        = (k != off_at);
      flush_req    = (k == flush_at);
      if (k == len - 1 && pop_last) begin
        check_eq("R6 pop avail", 32'(pop_avail), 1);
        check_eq("R1 marker at head", pop_data, exp_q[0]);
        pop = 1'b1;
      end
      if (k == len - 1) irq_ack = ack_last;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; rx_en = 1'b1; flush_req = 1'b0;
    in_err_align = 1'b0; in_err_len = 1'b0; in_err_crc = 1'b0;
    pop = 1'b0; irq_ack = 1'b0;
    if (pop_last) model_pop();
    if (flush_at >= 0) begin
      exp_q.delete(); mark_q.delete(); exp_count = 0;
    end else if (off_at < 0) begin
      model_frame(len, tag, a, l, c);
    end
    check_eq("R6 frame count", 32'(frame_count), 32'(exp_count));
    if (ack_last) check_eq("R11 set beats ack", 32'(irq_rx), 1);
  endtask

  task automatic drain(string req);
    while (exp_q.size() > 0) begin
      check_eq({req, " avail"}, 32'(pop_avail), 1);
      check_eq({req, " word"}, pop_data, exp_q[0]);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      model_pop();
    end
    check_eq({req, " empty"}, 32'(pop_avail), 0);
    check_eq("R6 count after drain", 32'(frame_count), 32'(exp_count));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check_eq("R12 avail", 32'(pop_avail), 0);
    check_eq("R12 count", 32'(frame_count), 0);
    check_eq("R12 irq", 32'(irq_rx), 0);
    check_eq("R12 busy", 32'(flush_busy), 0);

    // R1 R2 R3: short frames and partial last words
    send(1, 1, 0, 0, 0, -1, -1, 0, 0);
    check_eq("R11 event set", 32'(irq_rx), 1);
    drain("R1 R3 one byte");
    send(4, 2, 0, 0, 0, -1, -1, 0, 0);
    send(7, 3, 0, 0, 1, -1, -1, 0, 0);
    send(9, 4, 1, 1, 0, -1, -1, 0, 0);
    drain("R2 R3 status and packing");

    // R11 acknowledge, then acknowledge colliding with a completion
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check_eq("R11 ack clears", 32'(irq_rx), 0);
    send(6, 5, 0, 0, 0, -1, -1, 0, 1);

    // R6 completion in the same cycle as a marker pop
    send(10, 6, 0, 0, 0, -1, -1, 1, 0);
    drain("R6 simultaneous");

    // R4 pop while empty
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    check_eq("R4 empty pop", 32'(pop_avail), 0);
    send(5, 7, 0, 0, 0, -1, -1, 0, 0);
    drain("R4 after empty pop");

    // R9 enable dropped mid-frame and on the first byte
    send(10, 8, 0, 0, 0, 3, -1, 0, 0);
    send(6, 9, 0, 0, 0, 0, -1, 0, 0);
    check_eq("R9 dropped", 32'(pop_avail), 0);
    send(8, 10, 0, 0, 0, -1, -1, 0, 0);
    drain("R9 next frame");

    // R10 fill to exactly full, overflow mid-frame, then a small reject
    for (int i = 0; i < 5; i++) send(40, 20 + i, 0, 0, 0, -1, -1, 0, 0);
    send(40, 30, 0, 0, 0, -1, -1, 0, 0);
    send(8, 31, 0, 0, 0, -1, -1, 0, 0);
    check_eq("R10 exact fill count", 32'(frame_count), 6);
    send(1, 32, 0, 0, 0, -1, -1, 0, 0);
    drain("R10 overflow");
    send(3, 33, 0, 0, 0, -1, -1, 0, 0);
    drain("R10 after overflow");

    // R7 counter clear leaves data readable
    send(5, 40, 0, 0, 0, -1, -1, 0, 0);
    send(5, 41, 0, 0, 0, -1, -1, 0, 0);
    count_clear = 1'b1; @(negedge clk); count_clear = 1'b0;
    check_eq("R7 count cleared", 32'(frame_count), 0);
    exp_count = 0;
    drain("R7 data kept");

    // R8 flush with a stored record and a frame in flight
    send(6, 50, 0, 0, 0, -1, -1, 0, 0);
    send(12, 51, 0, 0, 0, -1, 4, 0, 0);
    check_eq("R8 flushed", 32'(pop_avail), 0);
    send(7, 52, 0, 0, 0, -1, -1, 0, 0);
    drain("R8 after flush");

    // Random mix of lengths, errors and enable drops
    for (int it = 0; it < 36; it++) begin
      int len;
      int off;
      len = 1 + int'($urandom % 30);
      off = ($urandom % 8 == 0) ? int'($urandom % len) : -1;
      send(len, 100 + it, ($urandom % 5) == 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, off, -1, 0, 0);
      if (it % 3 == 2) drain("R3 random");
    end
    drain("R3 random final");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule